// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds the system clock control word of a microcontroller-class chip, along with the five-bit clock divider setting that the word controls. A CPU reaches both through a simple register bus made of an address, write data, a write strobe and combinational read data. The block drives three things to the clock generator: a stop-mode request, a CPU clock source select (main or PLL), and the divider value.

Every write is guarded by a protect-enable input. On top of that, each field can be frozen by lock and mode inputs:

- a clock-change lock;
- a lock that is active while the watchdog runs from the on-chip oscillator;
- oscillation-stop detection being enabled;
- the on-chip oscillator being selected.

When stop mode is entered, the divider is forced to divide-by-8 in the same cycle. An external wake-up pulse clears the stop request.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset, the control word reads 0x20, stopReq and pllSel are 0, and the divider holds DIV_RESET (default 5'b00100). The divider address reads {3'b000, divider}.
- R2: The control word always reads back as {pllSel, 0, 1, 0000, stopReq}. Bit 0 is stop, bit 7 is the clock select, bit 5 reads 1, and bits 6 and 4..1 read 0, whatever value is written to them.
- R3: With protectEn=1 and no lock active, a write to CTRL_ADDR (default 0) loads bit 0 into stopReq and bit 7 into pllSel on the next clock edge.
- R4: While protectEn=0, writes to the control address and to the divider address change no output.
- R5: When stopReq goes from 0 to 1, the divider reads 5'b01000 on the same edge. Writing 1 while stopReq is already 1 leaves the divider unchanged.
- R6: While clkChangeLock=1, a control write changes neither stopReq nor pllSel.
- R7: While wdtOscLock=1, a control write leaves stopReq unchanged, but pllSel is still written.
- R8: While onChipOscSel=1, a control write leaves pllSel unchanged and cannot set stopReq.
- R9: While oscStopDetEn=1, a control write cannot set stopReq. Writing 0 still clears it.
- R10: With protectEn=1, a write to DIV_ADDR (default 1) loads write data bits 4..0 into the divider on the next edge.
- R11: A wakePulse clears stopReq on the next edge regardless of protection or locks, and it wins over a same-cycle write that sets stop.
- R12: Any other address reads 0, and writing to it changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRdData | output | 8 | Read data for busAddr |
| protectEn | input | 1 | 1 allows writes |
| clkChangeLock | input | 1 | Freezes stop and clock select |
| wdtOscLock | input | 1 | Freezes stop |
| oscStopDetEn | input | 1 | Oscillation-stop detection enabled |
| onChipOscSel | input | 1 | On-chip oscillator selected |
| wakePulse | input | 1 | Clears the stop request |
| stopReq | output | 1 | Stop-mode request |
| pllSel | output | 1 | CPU clock source: 0 main, 1 PLL |
| divSetting | output | DIV_W | Clock divider value |

## Verification
The bench sweeps all 32 combinations of the protect and gating inputs against every stop and select data pair, starting from both stop states. This catches a design that lets one lock leak into another field, for example the watchdog lock wrongly freezing the clock select. Starting from a stopped state with the divider rewritten exposes a design that forces divide-by-8 on every stop write instead of only on entry. A same-cycle wake and set shows whether wake-up priority is honoured. Writes filled with reserved-bit garbage and writes to an unmapped address show whether a design lets reserved bits or stray addresses leak into read-back.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  typedef struct packed {
    logic setStop;
    logic clrStop;
    logic loadPll;
    logic pllVal;
    logic loadDiv;
    logic forceDiv;
  } clkStrobes_t;
endpackage

// File: rtl/clk_ctrl_decode.sv
module clk_ctrl_decode
  import clk_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int DIV_ADDR  = 1
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrStop,
  input  logic              wrPll,
  input  logic              protectEn,
  input  logic              clkChangeLock,
  input  logic              wdtOscLock,
  input  logic              oscStopDetEn,
  input  logic              onChipOscSel,
  input  logic              wakePulse,
  input  logic              curStop,
  output clkStrobes_t       strb,
  output logic              rdSelCtrl,
  output logic              rdSelDiv
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] DIV_A  = ADDR_W'(DIV_ADDR);

  logic ctrlHit, divHit, stopWritable, stopAllowed;

  always_comb begin
    rdSelCtrl    = (busAddr == CTRL_A);
    rdSelDiv     = (busAddr == DIV_A);
    ctrlHit      = busWr && rdSelCtrl && protectEn;
    divHit       = busWr && rdSelDiv && protectEn;
    stopWritable = ctrlHit && !clkChangeLock && !wdtOscLock;
    stopAllowed  = !oscStopDetEn && !onChipOscSel;

    strb.clrStop  = wakePulse || (stopWritable && !wrStop);
    strb.setStop  = stopWritable && wrStop && stopAllowed && !wakePulse && !curStop;
    strb.forceDiv = stopWritable && wrStop && stopAllowed && !wakePulse && !curStop;
    strb.loadPll  = ctrlHit && !clkChangeLock && !onChipOscSel;
    strb.pllVal   = wrPll;
    strb.loadDiv  = divHit;
  end
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
  import clk_ctrl_pkg::*;
#(
  parameter int          DIV_W     = 5,
  parameter logic [4:0]  DIV_RESET = 5'b00100,
  parameter logic [4:0]  DIV_STOP  = 5'b01000
) (
  input  logic             clk,
  input  logic             rstN,
  input  clkStrobes_t      strb,
  input  logic [DIV_W-1:0] divIn,
  input  logic             rdSelCtrl,
  input  logic             rdSelDiv,
  output logic             stopQ,
  output logic             pllQ,
  output logic [DIV_W-1:0] divQ,
  output logic [7:0]       rdData
);
  localparam logic [7:0] RSV_VALUE = 8'h20;
  localparam int         PAD_W     = 8 - DIV_W;

  logic [7:0] ctrlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopQ <= 1'b0;
      pllQ  <= 1'b0;
      divQ  <= DIV_W'(DIV_RESET);
    end else begin
      if (strb.clrStop)      stopQ <= 1'b0;
      else if (strb.setStop) stopQ <= 1'b1;
      if (strb.loadPll)      pllQ  <= strb.pllVal;
      if (strb.forceDiv)     divQ  <= DIV_W'(DIV_STOP);
      else if (strb.loadDiv) divQ  <= divIn;
    end
  end

  always_comb begin
    ctrlWord    = RSV_VALUE;
    ctrlWord[0] = stopQ;
    ctrlWord[7] = pllQ;
    if (rdSelCtrl)     rdData = ctrlWord;
    else if (rdSelDiv) rdData = {{PAD_W{1'b0}}, divQ};
    else               rdData = 8'h00;
  end

  assert_stop_forces_div_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopQ) |-> (divQ == DIV_W'(DIV_STOP)));
  assert_reserved_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdSelCtrl |-> (rdData[6:1] == 6'b010000));
  assert_wake_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStop |=> !stopQ);
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
  import clk_ctrl_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter int         CTRL_ADDR = 0,
  parameter int         DIV_ADDR  = 1,
  parameter int         DIV_W     = 5,
  parameter logic [4:0] DIV_RESET = 5'b00100,
  parameter logic [4:0] DIV_STOP  = 5'b01000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWr,
  output logic [7:0]        busRdData,
  input  logic              protectEn,
  input  logic              clkChangeLock,
  input  logic              wdtOscLock,
  input  logic              oscStopDetEn,
  input  logic              onChipOscSel,
  input  logic              wakePulse,
  output logic              stopReq,
  output logic              pllSel,
  output logic [DIV_W-1:0]  divSetting
);
  clkStrobes_t strb;
  logic rdSelCtrl, rdSelDiv;
  logic unusedWrBits;
  assign unusedWrBits = ^busWrData[6:DIV_W];

  clk_ctrl_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DIV_ADDR(DIV_ADDR)) uDecode (
    .busWr(busWr), .busAddr(busAddr), .wrStop(busWrData[0]), .wrPll(busWrData[7]),
    .protectEn(protectEn), .clkChangeLock(clkChangeLock), .wdtOscLock(wdtOscLock),
    .oscStopDetEn(oscStopDetEn), .onChipOscSel(onChipOscSel), .wakePulse(wakePulse),
    .curStop(stopReq), .strb(strb), .rdSelCtrl(rdSelCtrl), .rdSelDiv(rdSelDiv));

  clk_ctrl_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .DIV_STOP(DIV_STOP)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .divIn(busWrData[DIV_W-1:0]),
    .rdSelCtrl(rdSelCtrl), .rdSelDiv(rdSelDiv), .stopQ(stopReq), .pllQ(pllSel),
    .divQ(divSetting), .rdData(busRdData));

  assert_protect_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!protectEn && !wakePulse) |=> ($stable(stopReq) && $stable(pllSel) && $stable(divSetting)));
  assert_change_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clkChangeLock && !wakePulse) |=> ($stable(stopReq) && $stable(pllSel)));
  assert_wdt_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wdtOscLock && !wakePulse) |=> $stable(stopReq));
  assert_onchip_pll_R8: assert property (@(posedge clk) disable iff (!rstN)
    onChipOscSel |=> $stable(pllSel));
  assert_no_stop_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((oscStopDetEn || onChipOscSel) && !stopReq) |=> !stopReq);
  assert_stray_addr_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !wakePulse && (busAddr != ADDR_W'(CTRL_ADDR)) && (busAddr != ADDR_W'(DIV_ADDR)))
      |=> ($stable(stopReq) && $stable(pllSel) && $stable(divSetting)));
endmodule

// File: tb/tb_clk_ctrl_reg.sv
`timescale 1ns/1ps
module tb_clk_ctrl_reg;
  logic clk = 0, rstN = 0;
  logic [3:0] busAddr = 0;
  logic [7:0] busWrData = 0, busRdData;
  logic busWr = 0, protectEn = 1, clkChangeLock = 0, wdtOscLock = 0;
  logic oscStopDetEn = 0, onChipOscSel = 0, wakePulse = 0;
  logic stopReq, pllSel;
  logic [4:0] divSetting;
  int checks = 0, errors = 0;
  bit done = 0;
  logic mStop, mPll;
  logic [4:0] mDiv;

  always #2.5 clk = ~clk;

  clk_ctrl_reg dut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRdData(busRdData), .protectEn(protectEn), .clkChangeLock(clkChangeLock),
    .wdtOscLock(wdtOscLock), .oscStopDetEn(oscStopDetEn), .onChipOscSel(onChipOscSel),
    .wakePulse(wakePulse), .stopReq(stopReq), .pllSel(pllSel), .divSetting(divSetting));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d, logic wake);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1; wakePulse = wake;
    @(negedge clk);
    busWr = 0; wakePulse = 0;
  endtask

  task automatic readAt(logic [3:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  // model of a control write, from the requirements
  task automatic modelCtrl(logic [7:0] d);
    if (protectEn) begin
      if (!clkChangeLock && !onChipOscSel) mPll = d[7];          // R3 R6 R8
      if (!clkChangeLock && !wdtOscLock) begin                     // R6 R7
        if (!d[0]) mStop = 0;
        else if (!oscStopDetEn && !onChipOscSel && !mStop) begin   // R8 R9
          mStop = 1; mDiv = 5'b01000;                              // R5
        end
      end
    end
  endtask

  task automatic checkAll(string req);
    logic [7:0] rd;
    check(req, {7'd0, stopReq}, {7'd0, mStop});
    check(req, {7'd0, pllSel}, {7'd0, mPll});
    check(req, {3'd0, divSetting}, {3'd0, mDiv});
    readAt(4'd0, rd);
    check({req, " R2"}, rd, {mPll, 6'b010000, mStop});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    mStop = 0; mPll = 0; mDiv = 5'b00100;
    checkAll("R1");
    readAt(4'd1, rd); check("R1 div read", rd, 8'h04);

    // R3..R9 sweep of gating inputs, data pairs and starting stop state
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int d = 0; d < 4; d++) begin
        for (int pre = 0; pre < 2; pre++) begin
          logic [4:0] seed;
          logic [7:0] wd;
          seed = 5'((cfg * 7 + d * 3 + pre) ^ 5'h11);
          protectEn = 1; clkChangeLock = 0; wdtOscLock = 0; oscStopDetEn = 0; onChipOscSel = 0;
          busWrite(4'd2, 8'h00, 1'b1);            // wake clears stop
          mStop = 0;
          busWrite(4'd0, {~d[1], 6'b111111, pre[0]}, 1'b0);
          modelCtrl({~d[1], 6'b111111, pre[0]});
          busWrite(4'd1, {3'b111, seed}, 1'b0);     // R10
          mDiv = seed;
          check("R10", {3'd0, divSetting}, {3'd0, seed});
          protectEn = cfg[0]; clkChangeLock = cfg[1]; wdtOscLock = cfg[2];
          oscStopDetEn = cfg[3]; onChipOscSel = cfg[4];
          wd = {d[1], 6'b101011, d[0]};
          busWrite(4'd0, wd, 1'b0);
          modelCtrl(wd);
          checkAll("R3-sweep R4 R5 R6 R7 R8 R9");
        end
      end
    end

    // R4 and R10: divider writes with and without protection
    clkChangeLock = 0; wdtOscLock = 0; oscStopDetEn = 0; onChipOscSel = 0;
    for (int v = 0; v < 32; v++) begin
      protectEn = 1;
      busWrite(4'd1, 8'(v), 1'b0);
      readAt(4'd1, rd); check("R10 div write", rd, 8'(v));
      protectEn = 0;
      busWrite(4'd1, 8'(31 - v), 1'b0);
      readAt(4'd1, rd); check("R4 div protected", rd, 8'(v));
    end
    mDiv = 5'd31;

    // R11: wake beats a same-cycle set, and works with protection off and locks on
    protectEn = 1;
    busWrite(4'd0, 8'h01, 1'b1);
    check("R11 wake priority", {7'd0, stopReq}, 8'd0);
    busWrite(4'd0, 8'h01, 1'b0);
    check("R11 setup stop", {7'd0, stopReq}, 8'd1);
    check("R5 forced div", {3'd0, divSetting}, 8'h08);
    protectEn = 0; clkChangeLock = 1; wdtOscLock = 1;
    busWrite(4'd3, 8'h00, 1'b1);
    check("R11 wake under locks", {7'd0, stopReq}, 8'd0);
    protectEn = 1; clkChangeLock = 0; wdtOscLock = 0;

    // R12: unmapped address
    busWrite(4'd0, 8'h80, 1'b0);
    busWrite(4'd1, 8'h05, 1'b0);
    busWrite(4'd7, 8'hFF, 1'b0);
    check("R12 stop", {7'd0, stopReq}, 8'd0);
    check("R12 pll", {7'd0, pllSel}, 8'd1);
    check("R12 div", {3'd0, divSetting}, 8'h05);
    readAt(4'd7, rd); check("R12 read", rd, 8'h00);
    readAt(4'd0, rd); check("R2 readback", rd, 8'hA0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule